// File: doc/BRIEF.md
# Calibration list sequencer

This block steps through a small circular list of calibration types, serving one entry at a time and advancing only on a periodic tick. An init pulse builds the list from a requested-type mask, keeping only the types the block supports. It clears the per-channel valid mask and arms the first entry. On each later tick the active entry, if running, waits for the measurement-busy flag to drop. It then collects one sub-sample and either restarts the measurement or, once enough sub-samples are in, issues a post-process strobe with the number of active receive chains.

When an entry completes, the sequencer moves to the next list entry. If that entry has not run yet, it is started at once and completion is withheld from the caller. Completion is reported only when no queued entry is left. An entry whose valid bit is cleared from outside is re-armed the next time it is the active entry on a tick. Ticks flagged as long-interval also emit a load-then-start pair of noise-floor strobes, whatever the list is doing.

Top module: `cal_list_sequencer`

## Requirements
- R1: Type bits are bit 0 IQ-mismatch, bit 1 ADC-gain, bit 2 ADC-DC, bit 3 temperature compensation. Only bits 0 and 3 of the requested mask enter the list, so `post_type_o` never shows bit 1 or bit 2.
- R2: The cycle after `init_i`, `valid_o` is all zero. If the list is not empty, `meas_start_o` pulses and the lowest-numbered listed type becomes active with its sub-sample count at zero and its state running.
- R3: A tick while the active entry runs and `busy_i` is high produces no collect, start or post strobe.
- R4: A tick while the active entry runs and `busy_i` is low pulses `collect_o`. If the incremented count is still below that type's sample count, `meas_start_o` pulses with it.
- R5: On the tick where the incremented count reaches the type's sample count (a count of 0 acts as 1), `post_o` pulses. With it come a one-hot `post_type_o` and a `post_chains_o` equal to the number of set bits in `chain_mask_i`.
- R6: When an entry finishes and the next entry in circular type order is still waiting, that entry is started in the same cycle (`meas_start_o`) and `cal_done_o` stays low.
- R7: `cal_done_o` is a one-cycle pulse, raised only with `post_o` when the entry after the finished one is not waiting.
- R8: A tick with the active entry not running and its valid bit clear re-arms the entry: `meas_start_o` pulses and counting restarts from zero. With the valid bit set, the tick has no effect.
- R9: Each tick with `long_i` high gives `nf_load_o` one cycle after the tick and `nf_start_o` one cycle after that, independent of list state and init.
- R10: A `valid_o` bit rises only with a `post_o` of that type; `valid_clr_i` bits clear `valid_o` bits in the next cycle.
- R11: With an empty list, ticks produce no start, collect, post or done strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Build the list, clear valid mask, arm first entry |
| tick_i | input | 1 | Periodic calibration tick |
| long_i | input | 1 | Long-interval flag qualifying a tick |
| busy_i | input | 1 | Measurement still in progress |
| chain_mask_i | input | CHAINS | Receive chain enable mask |
| req_types_i | input | NUM_TYPES | Requested calibration types at init |
| samples_i | input | NUM_TYPES*CNT_W | Per-type sub-sample count, type k at bits k*CNT_W |
| valid_clr_i | input | NUM_TYPES | Clear bits of the channel valid mask |
| meas_start_o | output | 1 | Start a measurement |
| collect_o | output | 1 | Collect one sub-sample |
| post_o | output | 1 | Post-process accumulated samples |
| post_chains_o | output | CHW | Active chain count with post strobe |
| post_type_o | output | NUM_TYPES | One-hot type being post-processed |
| valid_o | output | NUM_TYPES | Channel valid mask |
| nf_load_o | output | 1 | Load noise-floor history strobe |
| nf_start_o | output | 1 | Start noise-floor calibration strobe |
| cal_done_o | output | 1 | All pending entries completed |

## Verification
Assertions watch, every cycle, the relations between the output strobes. Post-process is one-hot and only carries supported types, done comes with post and never twice in a row, collect is paired with start or post, and noise-floor load is always followed by start. A valid bit rises only with a post of its type, and an empty list never starts a measurement. The bench's scenarios are needed to show the ordering through the list: the hand-off to a waiting entry, that done is withheld while an entry is queued, the exact sub-sample count and chain count, and re-arming after a cleared valid bit. A cycle-level reference model in the bench covers these under random ticks, busy flags and re-inits.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ent_state_t;
endpackage

// File: rtl/cal_entry_table.sv
module cal_entry_table #(
  parameter int NUM_TYPES = 4,
  parameter int CNT_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_TYPES-1:0]     set_wait_i,
  input  logic [NUM_TYPES-1:0]     arm_i,
  input  logic [NUM_TYPES-1:0]     inc_i,
  input  logic [NUM_TYPES-1:0]     done_i,
  output logic [2*NUM_TYPES-1:0]   state_o,
  output logic [NUM_TYPES*CNT_W-1:0] cnt_o
);
  import cal_seq_pkg::*;

  for (genvar g = 0; g < NUM_TYPES; g++) begin : g_ent
    ent_state_t       st_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        st_q  <= ST_WAIT;
        cnt_q <= '0;
      end else if (arm_i[g]) begin
        st_q  <= ST_RUN;
        cnt_q <= '0;
      end else begin
        if (set_wait_i[g]) begin
          st_q  <= ST_WAIT;
          cnt_q <= '0;
        end
        if (done_i[g]) st_q <= ST_DONE;
        if (inc_i[g])  cnt_q <= cnt_q + 1'b1;
      end
    end

    assign state_o[2*g +: 2]     = st_q;
    assign cnt_o[g*CNT_W +: CNT_W] = cnt_q;
  end

  // R6: the entry handed over to is never the one being closed
  p_cmd_excl_r6: assert property (@(posedge clk) disable iff (rst)
    (arm_i & done_i) == '0);
endmodule

// File: rtl/cal_next_pick.sv
module cal_next_pick #(
  parameter int NUM_TYPES = 4,
  localparam int IDX_W    = $clog2(NUM_TYPES)
) (
  input  logic [NUM_TYPES-1:0] en_i,
  input  logic [IDX_W-1:0]     from_i,
  output logic [IDX_W-1:0]     nxt_o,
  output logic                 found_o
);
  always_comb begin
    nxt_o   = '0;
    found_o = 1'b0;
    for (int k = NUM_TYPES; k >= 1; k--) begin
      int unsigned idx;
      idx = (int'(from_i) + k) % NUM_TYPES;
      if (en_i[idx]) begin
        nxt_o   = IDX_W'(idx);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cal_nf_strobe.sv
module cal_nf_strobe (
  input  logic clk,
  input  logic rst,
  input  logic long_tick_i,
  output logic load_o,
  output logic start_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      load_o  <= 1'b0;
      start_o <= 1'b0;
    end else begin
      load_o  <= long_tick_i;
      start_o <= load_o;
    end
  end

  p_nf_order_r9: assert property (@(posedge clk) disable iff (rst)
    load_o |=> start_o);
  p_nf_pair_r9: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(load_o));
endmodule

// File: rtl/cal_list_sequencer.sv
module cal_list_sequencer #(
  parameter int                  NUM_TYPES = 4,
  parameter int                  CNT_W     = 8,
  parameter int                  CHAINS    = 3,
  parameter logic [NUM_TYPES-1:0] SUPPORTED = 4'b1001,
  localparam int                 IDX_W     = $clog2(NUM_TYPES),
  localparam int                 CHW       = $clog2(CHAINS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       init_i,
  input  logic                       tick_i,
  input  logic                       long_i,
  input  logic                       busy_i,
  input  logic [CHAINS-1:0]          chain_mask_i,
  input  logic [NUM_TYPES-1:0]       req_types_i,
  input  logic [NUM_TYPES*CNT_W-1:0] samples_i,
  input  logic [NUM_TYPES-1:0]       valid_clr_i,
  output logic                       meas_start_o,
  output logic                       collect_o,
  output logic                       post_o,
  output logic [CHW-1:0]             post_chains_o,
  output logic [NUM_TYPES-1:0]       post_type_o,
  output logic [NUM_TYPES-1:0]       valid_o,
  output logic                       nf_load_o,
  output logic                       nf_start_o,
  output logic                       cal_done_o
);
  import cal_seq_pkg::*;

  logic [NUM_TYPES-1:0]       en_q, en_d;
  logic [IDX_W-1:0]           ptr_q, ptr_d;
  logic [NUM_TYPES-1:0]       set_wait, arm, inc, done_v, set_bits;
  logic [2*NUM_TYPES-1:0]     st_flat;
  logic [NUM_TYPES*CNT_W-1:0] cnt_flat;
  logic [IDX_W-1:0]           nxt_idx, first_idx;
  logic                       nxt_found, first_found;
  logic [NUM_TYPES-1:0]       init_en;
  ent_state_t                 cur_st, nxt_st;
  logic [CNT_W-1:0]           cur_cnt, cur_samp;
  logic                       start_d, collect_d, post_d, done_d, fin;
  logic [NUM_TYPES-1:0]       post_type_d, valid_d;
  logic [CHW-1:0]             chains_n;

  cal_entry_table #(.NUM_TYPES(NUM_TYPES), .CNT_W(CNT_W)) u_table (
    .clk(clk), .rst(rst), .set_wait_i(set_wait), .arm_i(arm),
    .inc_i(inc), .done_i(done_v), .state_o(st_flat), .cnt_o(cnt_flat));

  assign init_en = req_types_i & SUPPORTED;

  cal_next_pick #(.NUM_TYPES(NUM_TYPES)) u_next (
    .en_i(en_q), .from_i(ptr_q), .nxt_o(nxt_idx), .found_o(nxt_found));

  cal_next_pick #(.NUM_TYPES(NUM_TYPES)) u_first (
    .en_i(init_en), .from_i(IDX_W'(NUM_TYPES - 1)),
    .nxt_o(first_idx), .found_o(first_found));

  cal_nf_strobe u_nf (
    .clk(clk), .rst(rst), .long_tick_i(tick_i & long_i),
    .load_o(nf_load_o), .start_o(nf_start_o));

  assign cur_st   = ent_state_t'(st_flat[ptr_q*2 +: 2]);
  assign nxt_st   = ent_state_t'(st_flat[nxt_idx*2 +: 2]);
  assign cur_cnt  = cnt_flat[ptr_q*CNT_W +: CNT_W];
  assign cur_samp = samples_i[ptr_q*CNT_W +: CNT_W];

  always_comb begin
    chains_n = '0;
    for (int c = 0; c < CHAINS; c++) chains_n = chains_n + CHW'(chain_mask_i[c]);
  end

  always_comb begin
    set_wait    = '0;
    arm         = '0;
    inc         = '0;
    done_v      = '0;
    set_bits    = '0;
    start_d     = 1'b0;
    collect_d   = 1'b0;
    post_d      = 1'b0;
    post_type_d = '0;
    done_d      = 1'b0;
    fin         = 1'b0;
    ptr_d       = ptr_q;
    en_d        = en_q;
    if (init_i) begin
      en_d     = init_en;
      set_wait = init_en;
      ptr_d    = '0;
      if (first_found) begin
        ptr_d          = first_idx;
        arm[first_idx] = 1'b1;
        start_d        = 1'b1;
      end
    end else if (tick_i && (en_q != '0)) begin
      if (cur_st == ST_RUN) begin
        if (!busy_i) begin
          collect_d  = 1'b1;
          inc[ptr_q] = 1'b1;
          if (({1'b0, cur_cnt} + (CNT_W+1)'(1)) >= {1'b0, cur_samp}) begin
            post_d             = 1'b1;
            post_type_d[ptr_q] = 1'b1;
            set_bits[ptr_q]    = 1'b1;
            done_v[ptr_q]      = 1'b1;
            fin                = 1'b1;
          end else begin
            start_d = 1'b1;
          end
        end
      end else if (!valid_o[ptr_q]) begin
        arm[ptr_q] = 1'b1;
        start_d    = 1'b1;
      end
      if (fin && nxt_found) begin
        ptr_d = nxt_idx;
        if ((nxt_idx != ptr_q) && (nxt_st == ST_WAIT)) begin
          arm[nxt_idx] = 1'b1;
          start_d      = 1'b1;
        end else begin
          done_d = 1'b1;
        end
      end
    end
    valid_d = init_i ? '0 : ((valid_o & ~valid_clr_i) | set_bits);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q          <= '0;
      ptr_q         <= '0;
      valid_o       <= '0;
      meas_start_o  <= 1'b0;
      collect_o     <= 1'b0;
      post_o        <= 1'b0;
      post_type_o   <= '0;
      post_chains_o <= '0;
      cal_done_o    <= 1'b0;
    end else begin
      en_q          <= en_d;
      ptr_q         <= ptr_d;
      valid_o       <= valid_d;
      meas_start_o  <= start_d;
      collect_o     <= collect_d;
      post_o        <= post_d;
      post_type_o   <= post_type_d;
      post_chains_o <= post_d ? chains_n : '0;
      cal_done_o    <= done_d;
    end
  end

  p_post_supported_r1: assert property (@(posedge clk) disable iff (rst)
    post_o |-> ((post_type_o & ~SUPPORTED) == '0));
  p_post_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    post_o |-> ($countones(post_type_o) == 1));
  p_collect_pair_r4: assert property (@(posedge clk) disable iff (rst)
    collect_o |-> (meas_start_o || post_o));
  p_done_with_post_r7: assert property (@(posedge clk) disable iff (rst)
    cal_done_o |-> post_o);
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    cal_done_o |=> !cal_done_o);
  p_valid_rise_r10: assert property (@(posedge clk) disable iff (rst)
    ((valid_o & ~$past(valid_o)) != '0) |-> (post_o && ((valid_o & ~$past(valid_o)) == post_type_o)));
  p_idle_empty_r11: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0 && !init_i) |=> (!meas_start_o && !collect_o && !cal_done_o));
endmodule

// File: tb/cal_list_sequencer_test.sv
module cal_list_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst;
  logic init_i, tick_i, long_i, busy_i;
  logic [2:0] chain_mask_i;
  logic [NT-1:0] req_types_i, valid_clr_i;
  logic [NT*CW-1:0] samples_i;
  logic meas_start_o, collect_o, post_o, nf_load_o, nf_start_o, cal_done_o;
  logic [1:0] post_chains_o;
  logic [NT-1:0] post_type_o, valid_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_list_sequencer uut (
    .clk(clk), .rst(rst), .init_i(init_i), .tick_i(tick_i), .long_i(long_i),
    .busy_i(busy_i), .chain_mask_i(chain_mask_i), .req_types_i(req_types_i),
    .samples_i(samples_i), .valid_clr_i(valid_clr_i),
    .meas_start_o(meas_start_o), .collect_o(collect_o), .post_o(post_o),
    .post_chains_o(post_chains_o), .post_type_o(post_type_o), .valid_o(valid_o),
    .nf_load_o(nf_load_o), .nf_start_o(nf_start_o), .cal_done_o(cal_done_o));

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // reference model (0 wait, 1 run, 2 done)
  logic [NT-1:0] m_en, m_valid;
  int m_ptr;
  int m_st [NT];
  int m_cnt [NT];
  bit m_nfl;
  bit e_start, e_coll, e_post, e_nfl, e_nfs, e_done;
  int e_chains;
  logic [NT-1:0] e_ptype, e_valid;

  function automatic int next_of(logic [NT-1:0] en, int from);
    int r = -1;
    for (int k = NT; k >= 1; k--) if (en[(from + k) % NT]) r = (from + k) % NT;
    return r;
  endfunction

  function automatic int pop3(logic [2:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]);
  endfunction

  task automatic model_reset();
    m_en = '0; m_valid = '0; m_ptr = 0; m_nfl = 0;
    for (int i = 0; i < NT; i++) begin m_st[i] = 0; m_cnt[i] = 0; end
  endtask

  task automatic model_step();
    logic [NT-1:0] setb = '0;
    bit fin = 0;
    int samp, nx;
    e_start = 0; e_coll = 0; e_post = 0; e_done = 0; e_chains = 0; e_ptype = '0;
    e_nfs = m_nfl;
    e_nfl = tick_i & long_i;
    m_nfl = e_nfl;
    if (init_i) begin
      m_en = req_types_i & 4'b1001;
      for (int i = 0; i < NT; i++) if (m_en[i]) begin m_st[i] = 0; m_cnt[i] = 0; end
      nx = next_of(m_en, NT - 1);
      m_ptr = 0;
      if (nx >= 0) begin m_ptr = nx; m_st[nx] = 1; m_cnt[nx] = 0; e_start = 1; end
      m_valid = '0;
    end else begin
      if (tick_i && m_en != '0) begin
        samp = int'(samples_i[m_ptr*CW +: CW]);
        if (m_st[m_ptr] == 1) begin
          if (!busy_i) begin
            e_coll = 1;
            m_cnt[m_ptr]++;
            if (m_cnt[m_ptr] >= samp) begin
              e_post = 1; e_ptype[m_ptr] = 1'b1; setb[m_ptr] = 1'b1;
              e_chains = pop3(chain_mask_i); m_st[m_ptr] = 2; fin = 1;
            end else e_start = 1;
          end
        end else if (!m_valid[m_ptr]) begin
          m_st[m_ptr] = 1; m_cnt[m_ptr] = 0; e_start = 1;
        end
        if (fin) begin
          nx = next_of(m_en, m_ptr);
          if (nx != m_ptr && m_st[nx] == 0) begin
            m_st[nx] = 1; m_cnt[nx] = 0; e_start = 1;
          end else e_done = 1;
          m_ptr = nx;
        end
      end
      m_valid = (m_valid & ~valid_clr_i) | setb;
    end
    e_valid = m_valid;
  endtask

  task automatic chk(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic compare_all();
    chk("R4 meas_start", int'(meas_start_o), int'(e_start));
    chk("R4 collect", int'(collect_o), int'(e_coll));
    chk("R5 post", int'(post_o), int'(e_post));
    chk("R5 post_chains", int'(post_chains_o), e_chains);
    chk("R1 post_type", int'(post_type_o), int'(e_ptype));
    chk("R10 valid", int'(valid_o), int'(e_valid));
    chk("R9 nf_load", int'(nf_load_o), int'(e_nfl));
    chk("R9 nf_start", int'(nf_start_o), int'(e_nfs));
    chk("R7 done", int'(cal_done_o), int'(e_done));
  endtask

  task automatic do_cyc(input bit ini, input bit tk, input bit lg, input bit bz,
                        input logic [NT-1:0] clr);
    init_i = ini; tick_i = tk; long_i = lg; busy_i = bz; valid_clr_i = clr;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    init_i = 0; tick_i = 0; long_i = 0; valid_clr_i = '0;
  endtask

  task automatic set_samples(input int s0, input int s1, input int s2, input int s3);
    samples_i = {CW'(s3), CW'(s2), CW'(s1), CW'(s0)};
  endtask

  initial begin
    int wd = 0;
    while (!finished) begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=0", wd);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1; init_i = 0; tick_i = 0; long_i = 0; busy_i = 0;
    chain_mask_i = 3'b101; req_types_i = 4'b1111; valid_clr_i = '0;
    set_samples(3, 5, 5, 2);
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R2 reset outputs", int'({meas_start_o, collect_o, post_o, cal_done_o, valid_o}), 0);

    // R2 / R1: init with all four requested, only IQ and temperature listed
    do_cyc(1, 0, 0, 0, '0);
    chk("R2 start after init", int'(meas_start_o), 1);
    chk("R2 valid cleared", int'(valid_o), 0);
    // R3: busy holds off the sample
    do_cyc(0, 1, 0, 1, '0);
    chk("R3 no collect while busy", int'(collect_o | meas_start_o), 0);
    // R4: two sub-samples restart measurement
    do_cyc(0, 1, 0, 0, '0);
    chk("R4 collect with restart", int'({collect_o, meas_start_o}), 3);
    do_cyc(0, 0, 0, 0, '0);
    do_cyc(0, 1, 0, 0, '0);
    // R5 + R6: third sample finishes type 0, hands over to type 3
    do_cyc(0, 1, 0, 0, '0);
    chk("R5 post type0", int'(post_type_o), 1);
    chk("R5 chain count", int'(post_chains_o), 2);
    chk("R6 next started", int'(meas_start_o), 1);
    chk("R6 done withheld", int'(cal_done_o), 0);
    // type 3 needs two samples; chain mask changed
    chain_mask_i = 3'b111;
    do_cyc(0, 1, 0, 0, '0);
    do_cyc(0, 1, 0, 0, '0);
    chk("R1 post type3", int'(post_type_o), 8);
    chk("R7 done on final entry", int'(cal_done_o), 1);
    chk("R10 valid both set", int'(valid_o), 9);
    do_cyc(0, 0, 0, 0, '0);
    chk("R7 done one cycle", int'(cal_done_o), 0);
    // R8: active entry (type 0) done and valid: tick ignored
    do_cyc(0, 1, 0, 0, '0);
    chk("R8 valid entry ignored", int'(meas_start_o | collect_o), 0);
    // R10 clear, then R8 re-arm
    do_cyc(0, 0, 0, 0, 4'b0001);
    chk("R10 clear bit0", int'(valid_o), 8);
    do_cyc(0, 1, 0, 0, '0);
    chk("R8 re-arm start", int'(meas_start_o), 1);
    // R9: long tick while busy
    do_cyc(0, 1, 1, 1, '0);
    chk("R9 load strobe", int'(nf_load_o), 1);
    do_cyc(0, 0, 0, 0, '0);
    chk("R9 start strobe", int'(nf_start_o), 1);
    // R11 / R1: only ADC types requested gives empty list
    req_types_i = 4'b0110;
    do_cyc(1, 0, 0, 0, '0);
    chk("R11 no start on empty init", int'(meas_start_o), 0);
    do_cyc(0, 1, 0, 0, '0);
    chk("R11 tick on empty list", int'(meas_start_o | collect_o | post_o), 0);
    // single-entry list, zero sample count acts as one (R5, R7)
    req_types_i = 4'b1000; set_samples(1, 1, 1, 0);
    do_cyc(1, 0, 0, 0, '0);
    do_cyc(0, 1, 0, 0, '0);
    chk("R5 zero count finishes at once", int'(post_o), 1);
    chk("R7 single entry done", int'(cal_done_o), 1);

    // constrained random phase
    for (int n = 0; n < 6000; n++) begin
      bit ini, tk, lg, bz;
      logic [NT-1:0] clr;
      ini = ($urandom % 150) == 0;
      if (ini) begin
        req_types_i = NT'($urandom);
        set_samples($urandom % 5, $urandom % 5, $urandom % 5, $urandom % 5);
      end
      tk = ($urandom % 10) < 4;
      lg = tk && (($urandom % 8) == 0);
      bz = ($urandom % 2) == 0;
      clr = (($urandom % 25) == 0) ? NT'($urandom) : '0;
      chain_mask_i = 3'($urandom);
      do_cyc(ini, tk, lg, bz, clr);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule